// File: doc/BRIEF.md
# Cascaded 16-bit Match Timer

This block fuses two 8-bit up-counters into a single 16-bit timer. A low byte counter and a high byte counter advance together on a selected count tick. The high byte steps whenever the low byte rolls over. The combined count is compared with a 16-bit compare value built from two compare bytes. When the count has reached that value, the next tick returns it to zero, raises one interrupt flag and flips a match output.

Two mode bytes, held as levels, control the timer. The count tick comes either from a free-running system-clock prescaler or from an external event pin. The event pin is synchronized and edge-detected before use. The fused 16-bit mode is enabled only when three specific bits of the upper mode byte are all set. While that pattern is absent, the count holds. Bits of the mode bytes that belong to capture or PWM operation are accepted but have no effect here.

Top module: `cascade_match_timer`

## Requirements
- R1: During and straight after reset, `count` is 0000h, `irqFlag` is 0 and `matchOut` is 0.
- R2: Counting happens only while `modeHi[6]`, `modeHi[3]` and `modeHi[2]` are all 1. With any of them 0, `count` keeps its value. A start-bit rising edge can still clear it.
- R3: Each enabled count tick adds one to `count`, carrying from the low byte into the high byte. On a tick where `count` equals {`cmpHi`,`cmpLo`}, `count` becomes 0000h instead.
- R4: `modeLo[4:2]` selects the tick source. The encodings 000, 001, 010, 011, 100, 101 and 110 give one tick every 2, 4, 8, 32, 128, 512 and 1024 clocks. The tick fires when the low 1, 2, 3, 5, 7, 9 or 10 bits of a 10-bit prescaler, free-running from 0 at reset, are all ones.
- R5: With `modeLo[4:2]` = 111, each rising edge of `extClk` gives exactly one tick. The tick passes through two synchronizer flops. `count` changes on the third rising clock edge after `extClk` rises.
- R6: The start bit is `modeLo[0]`. While it is 0, `count` holds. On a 0-to-1 change, `count` is cleared to 0000h in that cycle and counting then continues. The clear takes priority over a tick.
- R7: The enable bit is `modeLo[1]`. While it is 0, counting pauses with `count` unchanged, and it resumes from the held value.
- R8: On the tick that wraps `count` to zero, `irqFlag` is set on that same clock edge. It stays set until `irqClr` is sampled high. A wrap in the same cycle as `irqClr` leaves the flag set.
- R9: `matchOut` inverts on every wrap tick and is otherwise unchanged.
- R10: `modeLo[7:5]`, `modeHi[7]`, `modeHi[5:4]` and `modeHi[1:0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | External event clock pin |
| modeLo | input | 8 | Lower mode byte: start, enable, clock select, unused bits |
| modeHi | input | 8 | Upper mode byte: three cascade-enable bits, unused bits |
| cmpLo | input | 8 | Compare value, low byte |
| cmpHi | input | 8 | Compare value, high byte |
| irqClr | input | 1 | Interrupt flag clear strobe |
| count | output | 16 | Current 16-bit count |
| irqFlag | output | 1 | Sticky interrupt flag |
| matchOut | output | 1 | Output that toggles on each match |

## Verification
The assertions assume the mode bytes are levels sampled once per clock, so a start-bit change is seen as a single rising edge. They also assume that `irqClr` is the only thing that lowers the flag. The stimulus drives every input on the falling clock edge, so each is stable for a whole cycle. Compare values are mostly drawn small so that wraps occur often. The external pin is held for at least a few clocks between changes, which keeps it within what the two-flop synchronizer can follow edge for edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef struct packed {
    logic clear;
    logic step;
  } cmtStrobes_t;

  localparam logic [2:0] SEL_EXT = 3'b111;

  // number of prescaler low bits that must be all ones for a tick
  function automatic int tapWidth(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 7;
      3'd5:    return 9;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/cmt_ticksrc.sv
module cmt_ticksrc
  import cmt_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic [2:0] sel,
  output logic       tick
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [PRE_W-1:0]    pre;
  logic [SYNC_MSB:0]   syncQ;
  logic                edgePrev;
  logic                extPulse;
  logic [PRE_W-1:0]    tapMask;
  logic                divTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pre <= '0;
    else       pre <= pre + 1'b1;
  end

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extClk;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_MSB-1:0], extClk};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgePrev <= 1'b0;
    else       edgePrev <= syncQ[SYNC_MSB];
  end

  assign extPulse = syncQ[SYNC_MSB] & ~edgePrev;

  always_comb begin
    tapMask = '0;
    for (int b = 0; b < PRE_W; b++) begin
      if (b < tapWidth(sel)) tapMask[b] = 1'b1;
    end
  end

  assign divTick = ((pre & tapMask) == tapMask);
  assign tick    = (sel == SEL_EXT) ? extPulse : divTick;

endmodule

// File: rtl/cmt_control.sv
module cmt_control
  import cmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startBit,
  input  logic        enableBit,
  input  logic [2:0]  cascadeBits,
  input  logic        tick,
  input  logic        matchEvt,
  input  logic        irqClr,
  output cmtStrobes_t strobes,
  output logic        irqFlag,
  output logic        matchOut
);

  logic startPrev;
  logic cascadeOn;

  assign cascadeOn = &cascadeBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startPrev <= 1'b0;
    else       startPrev <= startBit;
  end

  always_comb begin
    strobes.clear = startBit & ~startPrev;
    strobes.step  = cascadeOn & startBit & enableBit & tick & ~strobes.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      matchOut <= 1'b0;
    end else begin
      irqFlag  <= matchEvt | (irqFlag & ~irqClr);
      matchOut <= matchOut ^ matchEvt;
    end
  end

endmodule

// File: rtl/cmt_datapath.sv
module cmt_datapath
  import cmt_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmtStrobes_t         strobes,
  input  logic [HALF_W-1:0]   cmpLo,
  input  logic [HALF_W-1:0]   cmpHi,
  output logic [2*HALF_W-1:0] count,
  output logic                matchEvt
);

  logic [HALF_W-1:0] lowQ;
  logic [HALF_W-1:0] highQ;
  logic              lowCarry;
  logic              atCompare;

  assign lowCarry  = &lowQ;
  assign atCompare = (lowQ == cmpLo) && (highQ == cmpHi);
  assign matchEvt  = strobes.step & atCompare;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ <= '0;
    end else if (strobes.clear || matchEvt) begin
      lowQ <= '0;
    end else if (strobes.step) begin
      lowQ <= lowQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highQ <= '0;
    end else if (strobes.clear || matchEvt) begin
      highQ <= '0;
    end else if (strobes.step && lowCarry) begin
      highQ <= highQ + 1'b1;
    end
  end

  assign count = {highQ, lowQ};

endmodule

// File: rtl/cascade_match_timer.sv
module cascade_match_timer
  import cmt_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extClk,
  input  logic [7:0]          modeLo,
  input  logic [7:0]          modeHi,
  input  logic [HALF_W-1:0]   cmpLo,
  input  logic [HALF_W-1:0]   cmpHi,
  input  logic                irqClr,
  output logic [2*HALF_W-1:0] count,
  output logic                irqFlag,
  output logic                matchOut
);

  cmtStrobes_t strobes;
  logic        tick;
  logic        matchEvt;
  logic        unusedModeBits;

  assign unusedModeBits = ^{modeLo[7:5], modeHi[7], modeHi[5:4], modeHi[1:0]};

  cmt_ticksrc #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) uTick (
    .clk    (clk),
    .rstN   (rstN),
    .extClk (extClk),
    .sel    (modeLo[4:2]),
    .tick   (tick)
  );

  cmt_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startBit    (modeLo[0]),
    .enableBit   (modeLo[1]),
    .cascadeBits ({modeHi[6], modeHi[3], modeHi[2]}),
    .tick        (tick),
    .matchEvt    (matchEvt),
    .irqClr      (irqClr),
    .strobes     (strobes),
    .irqFlag     (irqFlag),
    .matchOut    (matchOut)
  );

  cmt_datapath #(.HALF_W(HALF_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmpLo    (cmpLo),
    .cmpHi    (cmpHi),
    .count    (count),
    .matchEvt (matchEvt)
  );

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       modeLo,
  input logic [7:0]       modeHi,
  input logic             irqClr,
  input logic [CNT_W-1:0] count,
  input logic             irqFlag,
  input logic             matchOut
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count) && count != '0) |-> count == $past(count) + 1'b1); // R3

  AST_CASCADE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeHi[6] & modeHi[3] & modeHi[2]) |-> (count == $past(count) || count == '0)); // R2

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeLo[0]) |-> count == $past(count)); // R6

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeLo[1]) |-> (count == $past(count) || count == '0)); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqFlag) && !$past(irqClr)) |-> irqFlag); // R8

  AST_TOGGLE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(matchOut) |-> (irqFlag && count == '0)); // R9

endmodule

bind cascade_match_timer cmt_checker #(.CNT_W(2*HALF_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .modeLo   (modeLo),
  .modeHi   (modeHi),
  .irqClr   (irqClr),
  .count    (count),
  .irqFlag  (irqFlag),
  .matchOut (matchOut)
);

// File: tb/cascade_match_timer_test.sv
module cascade_match_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClk = 1'b0;
  logic [7:0]  modeLo = 8'h00;
  logic [7:0]  modeHi = 8'h00;
  logic [7:0]  cmpLo = 8'h00;
  logic [7:0]  cmpHi = 8'h00;
  logic        irqClr = 1'b0;
  logic [15:0] count;
  logic        irqFlag;
  logic        matchOut;

  int    vectors = 0;
  int    miscompares = 0;
  string curTag = "R1";
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  cascade_match_timer uut (
    .clk(clk), .rstN(rstN), .extClk(extClk), .modeLo(modeLo), .modeHi(modeHi),
    .cmpLo(cmpLo), .cmpHi(cmpHi), .irqClr(irqClr),
    .count(count), .irqFlag(irqFlag), .matchOut(matchOut)
  );

  // ---- reference model built from the requirements ----
  logic [9:0]  mPre;
  logic [2:0]  mSync;
  logic [15:0] mCount;
  logic        mIrq, mTog, mStartPrev;

  function automatic int bitsForSel(input logic [2:0] s);
    int widths[7] = '{1, 2, 3, 5, 7, 9, 10};
    return widths[s];
  endfunction

  function automatic logic refTick(input logic [2:0] s, input logic [9:0] p,
                                   input logic [2:0] sy);
    logic [9:0] m;
    if (s == 3'b111) return sy[1] & ~sy[2];
    m = 10'((1 << bitsForSel(s)) - 1);
    return (p & m) == m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic rise, stepOk, wrap;
    if (!rstN) begin
      mPre <= '0; mSync <= '0; mCount <= '0;
      mIrq <= 1'b0; mTog <= 1'b0; mStartPrev <= 1'b0;
    end else begin
      rise   = modeLo[0] & ~mStartPrev;
      stepOk = modeHi[6] & modeHi[3] & modeHi[2] & modeLo[0] & modeLo[1]
               & refTick(modeLo[4:2], mPre, mSync) & ~rise;
      wrap   = stepOk && (mCount == {cmpHi, cmpLo});
      mPre       <= mPre + 10'd1;
      mSync      <= {mSync[1:0], extClk};
      mStartPrev <= modeLo[0];
      if (rise)        mCount <= '0;
      else if (wrap)   mCount <= '0;
      else if (stepOk) mCount <= mCount + 16'd1;
      mIrq <= wrap | (mIrq & ~irqClr);
      mTog <= mTog ^ wrap;
    end
  end

  task automatic check(input string tag, input string sig,
                       input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(curTag, "count", count, mCount);
    check(curTag, "irqFlag", {15'd0, irqFlag}, {15'd0, mIrq});
    check(curTag, "matchOut", {15'd0, matchOut}, {15'd0, mTog});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  // modeHi with the three cascade bits set
  localparam logic [7:0] CASC = 8'h4C;

  function automatic logic [7:0] loMode(input logic [2:0] s, input logic en, input logic st);
    return {3'b000, s, en, st};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd6151);

    // R1: reset state
    curTag = "R1";
    run(4);
    check("R1", "count@reset", count, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    run(2);
    check("R1", "irq@reset", {15'd0, irqFlag}, 16'h0000);

    // R3: count up to compare value and wrap, across a carry
    curTag = "R3";
    modeHi = CASC; cmpHi = 8'h01; cmpLo = 8'h02;
    modeLo = loMode(3'd0, 1'b1, 1'b1);
    run(700);
    cmpHi = 8'h00; cmpLo = 8'h05;
    modeLo = loMode(3'd0, 1'b1, 1'b0); run(3);
    modeLo = loMode(3'd0, 1'b1, 1'b1);
    run(1);
    check("R3", "count after start clear", count, 16'h0000);
    run(60);

    // R4: every prescaler tap
    curTag = "R4";
    cmpLo = 8'h02;
    for (int s = 0; s < 7; s++) begin
      modeLo = loMode(3'(s), 1'b1, 1'b1);
      run(s < 5 ? 700 : 4200);
    end

    // R5: external event clock
    curTag = "R5";
    cmpLo = 8'h06;
    modeLo = loMode(3'd0, 1'b1, 1'b0); run(2);
    modeLo = loMode(3'b111, 1'b1, 1'b1); run(4);
    extClk = 1'b1;
    run(2);
    check("R5", "count before 3rd edge", count, 16'h0000);
    run(1);
    check("R5", "count after 3rd edge", count, 16'h0001);
    for (int i = 0; i < 40; i++) begin
      extClk = ~extClk;
      run(3 + (i % 3));
    end

    // R6: stop holds, restart clears
    curTag = "R6";
    cmpLo = 8'h40; modeLo = loMode(3'd0, 1'b1, 1'b1); run(30);
    modeLo = loMode(3'd0, 1'b1, 1'b0); run(20);
    modeLo = loMode(3'd0, 1'b1, 1'b1); run(30);

    // R7: enable pauses without clearing
    curTag = "R7";
    modeLo = loMode(3'd0, 1'b0, 1'b1); run(20);
    modeLo = loMode(3'd0, 1'b1, 1'b1); run(20);

    // R2: any missing cascade bit freezes the count
    curTag = "R2";
    foreach (CASC[b]) begin
      if (CASC[b]) begin
        modeHi = CASC & ~(8'h01 << b);
        run(16);
        modeHi = CASC;
        run(8);
      end
    end

    // R8 / R9: compare of zero wraps every tick, clear held high
    curTag = "R8";
    cmpLo = 8'h00; cmpHi = 8'h00;
    run(10);
    irqClr = 1'b1; run(12);
    irqClr = 1'b0; run(6);
    curTag = "R9";
    cmpLo = 8'h03; run(40);

    // R10: ignored bits flipping while counting
    curTag = "R10";
    cmpLo = 8'h09;
    for (int i = 0; i < 60; i++) begin
      modeLo = {3'($urandom), 3'd0, 1'b1, 1'b1};
      modeHi = CASC | ($urandom & 8'hB3);
      run(3);
    end

    // random mix
    curTag = "R3";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 19) == 0) extClk = ~extClk;
      if ($urandom_range(0, 39) == 0) modeLo = {3'($urandom), (($urandom_range(0, 3) == 0) ? 3'b111 : 3'($urandom_range(0, 2))),
                                              ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) != 0)};
      if ($urandom_range(0, 49) == 0) modeHi = ($urandom_range(0, 4) != 0) ? (CASC | 8'($urandom & 8'hB3)) : 8'($urandom);
      if ($urandom_range(0, 99) == 0) begin
        cmpLo = 8'($urandom_range(0, 15));
        cmpHi = ($urandom_range(0, 7) == 0) ? 8'd1 : 8'd0;
      end
      irqClr = ($urandom_range(0, 15) == 0);
      run(1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule